// File: doc/BRIEF.md
# Programmable PWM Channel with Two-Stage Clock Divider

This block produces one pulse-width-modulated output. A counting tick is derived from one of two time bases: a bus-clock tick or a fixed oscillator tick. Both arrive as single-cycle clock-enable pulses in the block's own clock domain. The selected pulses pass first through a power-of-two divider and then through a linear prescaler. Each resulting tick advances a 16-bit period counter. The output sits at the active level for the first part of every period and at the inactive level for the rest. Polarity is programmable.

Software programs the channel through a single-cycle write port addressed by a 2-bit selector. There are four words: clock selection, control, period, and run. The channel counts only while both its gate bit and its enable bit are set. When the channel is not counting, the output rests at its inactive level. Configuration writes apply at once, even in the middle of a period. Enabling the channel restarts every counter from zero.

Top module: `pwm_chan_gen`

## Requirements
- R1: Bit 8 of the clock word (selector 0) picks the time base: 1 counts bus_tick pulses and 0 counts osc_tick pulses. Pulses on the unselected input have no effect on the output.
- R2: Bits [3:0] of the clock word hold an exponent M, and the selected pulses are divided by 2^M. Values 0 to 8 divide by 1 to 256, and any value above 8 divides by 256.
- R3: Bits [7:0] of the control word (selector 1) hold K, and the divided pulses are further divided by K+1 (1 to 256).
- R4: The period word (selector 2) holds the period length minus one in bits [31:16] and the active count A in bits [15:0], so one period lasts 1 to 65536 ticks.
- R5: Bit 16 of the control word sets polarity: 1 means active high and 0 means active low. Within each period the output is active for the first A ticks. A=0 gives a constant inactive output, and A at or above the period length gives a constant active output.
- R6: Whenever the channel is not counting, the output equals the inactive level given by the polarity bit.
- R7: A write takes effect on the clock edge that captures it, and the running period is not finished first. If the counter already lies beyond a shorter new period, it returns to zero on the next tick.
- R8: The run word (selector 3) has a gate in bit 0 and an enable in bit 1. The channel counts only while both are 1.
- R9: When counting starts, all counters begin at zero, so the output is active (for A>0) in the cycle right after the enabling write.
- R10: A write that changes M or K clears the divider and the prescaler, so the next tick comes a full new ratio after the write.
- R11: After synchronous reset, every field is zero except polarity, which is 1 (active high), so the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tick | input | 1 | Bus time-base enable pulse |
| osc_tick | input | 1 | Oscillator time-base enable pulse |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Word selector: 0 clock, 1 control, 2 period, 3 run |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume two things about the prescaler and the period counter. First, the prescaler changes only through a write that also clears it. Second, the period counter runs only while gate and enable are both held. Under those assumptions each counter stays within its programmed bound one cycle after it advances. All stimulus is applied away from the clock edge, and each write lasts one cycle. Before a new setting is loaded, the channel is disabled. The exceptions are the mid-period rewrite and the source-switch cases: there the write deliberately lands on a running channel, and the expected output is worked out tick by tick.

// File: rtl/pwmch_pkg.sv
`timescale 1ns/1ps
package pwmch_pkg;

    localparam int CNT_W   = 16;
    localparam int PRE_W   = 8;
    localparam int EXP_W   = 4;
    localparam int MAX_EXP = 8;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 32;

    // bit positions decoded from the written words
    localparam int SRC_BIT  = 8;
    localparam int POL_BIT  = 16;
    localparam int GATE_BIT = 0;
    localparam int EN_BIT   = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CLOCK  = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_RUN    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             src_bus;
        logic [EXP_W-1:0] div_exp;
        logic [PRE_W-1:0] pre_k;
        logic             act_high;
        logic [CNT_W-1:0] per_m1;
        logic [CNT_W-1:0] act_cnt;
        logic             gate;
        logic             en;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        src_bus:  1'b0,
        div_exp:  '0,
        pre_k:    '0,
        act_high: 1'b1,
        per_m1:   '0,
        act_cnt:  '0,
        gate:     1'b0,
        en:       1'b0
    };

    localparam logic [MAX_EXP:0] ONE_WIDE = 1;

    // terminal count of the power-of-two divider, exponent clamped
    function automatic logic [MAX_EXP-1:0] div_limit(input logic [EXP_W-1:0] e);
        int eff;
        logic [MAX_EXP:0] pow;
        eff = (int'(e) > MAX_EXP) ? MAX_EXP : int'(e);
        pow = ONE_WIDE << eff;
        return MAX_EXP'(pow - ONE_WIDE);
    endfunction

endpackage

// File: rtl/pwmch_tick_chain.sv
`timescale 1ns/1ps
module pwmch_tick_chain #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div_lim,
    input  logic [PRE_W-1:0] pre_k,
    output logic             cnt_tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [PRE_W-1:0] pre_cnt;
    logic             div_wrap;
    logic             pre_wrap;

    assign div_wrap = src_tick && (div_cnt >= div_lim);
    assign pre_wrap = (pre_cnt >= pre_k);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            div_cnt <= '0;
            pre_cnt <= '0;
        end else if (src_tick) begin
            if (div_wrap) begin
                div_cnt <= '0;
                pre_cnt <= pre_wrap ? '0 : pre_cnt + PRE_W'(1);
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign cnt_tick = run && !restart && div_wrap && pre_wrap;

    // R3: prescaler never passes the programmed K while running undisturbed
    a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
        (run && !restart) |=> (pre_cnt <= $past(pre_k)));

endmodule

// File: rtl/pwmch_period_gen.sv
`timescale 1ns/1ps
module pwmch_period_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_m1,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic             act_high,
    output logic             pwm_o
);

    logic [CNT_W-1:0] cnt;
    logic             in_active;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt >= per_m1) ? '0 : cnt + CNT_W'(1);
        end
    end

    assign in_active = run && (cnt < act_cnt);
    assign pwm_o     = in_active ? act_high : !act_high;

    // R4: after a tick the position lies inside the period in force at that tick
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (cnt <= $past(per_m1)));

    // R9: counting always starts from the first position of a period
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/pwm_chan_gen.sv
`timescale 1ns/1ps
module pwm_chan_gen
    import pwmch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_tick,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    chan_cfg_t          cfg_q;
    reg_sel_e           sel;
    logic               run;
    logic               chain_restart;
    logic               src_tick;
    logic               cnt_tick;
    logic [MAX_EXP-1:0] div_lim;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CLOCK: begin
                    cfg_q.src_bus <= wr_data[SRC_BIT];
                    cfg_q.div_exp <= wr_data[EXP_W-1:0];
                end
                SEL_CTRL: begin
                    cfg_q.act_high <= wr_data[POL_BIT];
                    cfg_q.pre_k    <= wr_data[PRE_W-1:0];
                end
                SEL_PERIOD: begin
                    cfg_q.per_m1  <= wr_data[DATA_W-1:CNT_W];
                    cfg_q.act_cnt <= wr_data[CNT_W-1:0];
                end
                SEL_RUN: begin
                    cfg_q.gate <= wr_data[GATE_BIT];
                    cfg_q.en   <= wr_data[EN_BIT];
                end
            endcase
        end
    end

    always_comb begin
        chain_restart = 1'b0;
        if (wr_en) begin
            if (sel == SEL_CLOCK && wr_data[EXP_W-1:0] != cfg_q.div_exp)
                chain_restart = 1'b1;
            if (sel == SEL_CTRL && wr_data[PRE_W-1:0] != cfg_q.pre_k)
                chain_restart = 1'b1;
        end
    end

    assign run      = cfg_q.gate && cfg_q.en;
    assign src_tick = cfg_q.src_bus ? bus_tick : osc_tick;
    assign div_lim  = div_limit(cfg_q.div_exp);

    pwmch_tick_chain #(
        .DIV_W (MAX_EXP),
        .PRE_W (PRE_W)
    ) chain_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .restart  (chain_restart),
        .src_tick (src_tick),
        .div_lim  (div_lim),
        .pre_k    (cfg_q.pre_k),
        .cnt_tick (cnt_tick)
    );

    pwmch_period_gen #(
        .CNT_W (CNT_W)
    ) period_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (cnt_tick),
        .per_m1   (cfg_q.per_m1),
        .act_cnt  (cfg_q.act_cnt),
        .act_high (cfg_q.act_high),
        .pwm_o    (pwm_out)
    );

    // R6: a stopped channel rests at the inactive level
    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        !(cfg_q.gate && cfg_q.en) |-> (pwm_out != cfg_q.act_high));

    // R5: active count covering the whole period pins the output active
    a_r5_full_active: assert property (@(posedge clk) disable iff (rst)
        (run && cfg_q.act_cnt > cfg_q.per_m1) |-> (pwm_out == cfg_q.act_high));

    // R5: zero active count keeps the output inactive
    a_r5_zero_inactive: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.act_cnt == '0) |-> (pwm_out != cfg_q.act_high));

endmodule

// File: tb/pwm_chan_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_tick = 1'b1;
    logic        osc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_chan_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_tick (bus_tick),
        .osc_tick (osc_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out)
    );

    // vector table: exponent, prescaler K, period-1, active count, polarity
    localparam int NV = 8;
    localparam int V_M  [NV] = '{0, 1, 2, 0, 3, 15, 0, 4};
    localparam int V_K  [NV] = '{0, 2, 0, 1, 0, 0, 255, 3};
    localparam int V_P  [NV] = '{9, 4, 3, 4, 1, 1, 0, 2};
    localparam int V_A  [NV] = '{3, 2, 0, 7, 1, 1, 1, 65535};
    localparam int V_POL[NV] = '{1, 1, 1, 0, 1, 1, 0, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input int d);
        wr_en   = 1'b1;
        wr_sel  = 2'(s);
        wr_data = 32'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input int src, input int m, input int k, input int p,
                         input int a, input int pol);
        wr(3, 0);
        wr(0, (src << 8) | m);
        wr(1, (pol << 16) | k);
        wr(2, (p << 16) | a);
    endtask

    task automatic count_active(input int n, input int pol, output int act);
        act = 0;
        repeat (n) begin
            if (int'(pwm_out) == pol) act++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int act;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state, active-high polarity, stopped, output low
        check(pwm_out == 1'b0, "R11 reset output", int'(pwm_out), 0);

        // R2 R3 R4 R5 R9 R6: table of duty windows
        for (int i = 0; i < NV; i++) begin
            int eff, t, len, exp_act, first_exp;
            eff = (V_M[i] > 8) ? 8 : V_M[i];
            t   = (1 << eff) * (V_K[i] + 1);
            len = V_P[i] + 1;
            exp_act   = ((V_A[i] < len) ? V_A[i] : len) * t;
            first_exp = (V_A[i] > 0) ? V_POL[i] : 1 - V_POL[i];
            setup(1, V_M[i], V_K[i], V_P[i], V_A[i], V_POL[i]);
            check(int'(pwm_out) == 1 - V_POL[i], "R6 idle before start", int'(pwm_out), 1 - V_POL[i]);
            wr(3, 3);
            check(int'(pwm_out) == first_exp, "R9 first cycle level", int'(pwm_out), first_exp);
            count_active(len * t, V_POL[i], act);
            check(act == exp_act, "R2 R3 R4 R5 active cycles per period", act, exp_act);
            wr(3, 1);
            check(int'(pwm_out) == 1 - V_POL[i], "R6 inactive after disable", int'(pwm_out), 1 - V_POL[i]);
        end

        // R1: oscillator source, bus pulses stopped
        bus_tick = 1'b0;
        osc_tick = 1'b1;
        setup(0, 0, 0, 3, 1, 1);
        wr(3, 3);
        count_active(4, 1, act);
        check(act == 1, "R1 osc source duty", act, 1);
        wr(3, 1);
        wr(3, 3);
        repeat (2) @(negedge clk);
        wr(0, (1 << 8) | 0);
        count_active(8, 1, act);
        check(act == 0, "R1 unselected osc pulses ignored", act, 0);
        bus_tick = 1'b1;
        osc_tick = 1'b0;

        // R8: gate and enable both needed
        setup(1, 0, 0, 0, 1, 1);
        wr(3, 1);
        count_active(10, 1, act);
        check(act == 0, "R8 gate only", act, 0);
        wr(3, 2);
        count_active(10, 1, act);
        check(act == 0, "R8 enable only", act, 0);
        wr(3, 3);
        count_active(10, 1, act);
        check(act == 10, "R8 gate and enable", act, 10);

        // R7: shorter period written mid-period
        setup(1, 0, 0, 99, 50, 1);
        wr(3, 3);
        repeat (5) @(negedge clk);
        wr(2, (3 << 16) | 1);
        check(pwm_out == 1'b0, "R7 counter past new active count", int'(pwm_out), 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R7 wrap to new period start", int'(pwm_out), 1);
        @(negedge clk);
        check(pwm_out == 1'b0, "R7 new period second tick", int'(pwm_out), 0);

        // R10: prescaler change restarts the chain
        setup(1, 0, 3, 9, 1, 1);
        wr(3, 3);
        @(negedge clk);
        wr(1, (1 << 16) | 5);
        count_active(6, 1, act);
        check(act == 6, "R10 full new ratio after write", act, 6);
        check(pwm_out == 1'b0, "R10 tick lands after six cycles", int'(pwm_out), 0);

        // R6 R11: polarity flip while stopped
        wr(3, 0);
        wr(1, 0);
        check(pwm_out == 1'b1, "R6 inactive high when active-low", int'(pwm_out), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule